// File: doc/BRIEF.md
# Multi-buffer DMA address offset aligner

This block sits between a set of streaming capture sources and a DMA write engine. Each channel rotates through several memory buffers. For every buffer of every channel the block keeps a 12-bit byte offset, so a buffer's data can start at any byte inside a 4 kB page. Each beat on the address stream carries a channel number, the buffer's base address and a running byte count. The block looks up the offset for that channel's current buffer index and places it inside the page of the base address. It then adds the byte count and sends the result on with one register stage of latency.

Offsets are loaded through a single register write port into a staging copy. A channel's staged offsets become live only when that channel's buffer index changes, so a buffer never sees its alignment change part-way through. The default build has twelve channels with eight buffers each. The channel mix is six 64-bit video streams, four generic parallel inputs and two audio streams, and all of them use the same datapath. Different buffers of one channel may use different offsets.

Top module: `dma_ofs_aligner`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1 and every live and staged offset is 0, so a beat leaves with `out_addr` equal to base plus count.
- R2: `out_addr` = ((base with bits [11:0] replaced by (base[11:0] + offset) mod 4096) + count) mod 2^ADDR_W. The offset never carries into bits [ADDR_W-1:12] of the base.
- R3: The offset applied to a beat is the live entry selected by that beat's channel (`in_ch`) and that channel's slice `buf_idx[ch*BUF_W +: BUF_W]`. The channels are independent of one another.
- R4: Each buffer of a channel holds its own offset. Writing entry (c, b) changes no other entry.
- R5: A write with `cfg_we`=1 stores `cfg_ofs` into the staged entry (`cfg_ch`, `cfg_buf`) and has no effect on output addresses until that channel's buffer index changes. At that change, all staged entries of that channel become live. Other channels are not affected.
- R6: A beat that is accepted in the same cycle as its channel's buffer index change already uses the newly live offsets.
- R7: A beat accepted at a clock edge (`in_valid` and `in_ready` high) appears on `out_valid`/`out_addr`/`out_ch` right after that edge. With `out_ready` high and no new input, `out_valid` falls after the next edge.
- R8: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and `out_addr`/`out_ch` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Offset write strobe |
| cfg_ch | input | CH_W (4) | Channel of the offset write |
| cfg_buf | input | BUF_W (3) | Buffer of the offset write |
| cfg_ofs | input | 12 | Byte offset value, 0..4095 |
| buf_idx | input | NUM_CH*BUF_W (36) | Current buffer index of every channel, channel c in bits [c*BUF_W +: BUF_W] |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_ch | input | CH_W (4) | Channel of the beat |
| in_base | input | ADDR_W (32) | Base address of the current buffer |
| in_count | input | CNT_W (16) | Running byte count inside the buffer |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_ch | output | CH_W (4) | Channel of the output beat |
| out_addr | output | ADDR_W (32) | Aligned write address |

## Verification
An accepted beat is due on the outputs exactly one edge later. A buffer index change commits offsets at the edge where the bench presents it, and a beat in that same cycle already uses the new offsets. The bench drives inputs on the falling edge and samples one falling edge after the accepting rising edge, which is the first point at which the registered result is visible. During a stall, the output and `in_ready` are sampled again after each further edge to confirm they are held. The cycle after the stall ends is checked for the queued beat.

// File: rtl/dma_ofs_pkg.sv
package dma_ofs_pkg;
  localparam int unsigned PAGE_BITS = 12;

  // Place a byte offset inside the page of a base address, then add the count.
  function automatic logic [63:0] place_in_page(input logic [63:0] base,
                                                input logic [PAGE_BITS-1:0] ofs,
                                                input logic [63:0] cnt);
    logic [PAGE_BITS-1:0] low;
    low = base[PAGE_BITS-1:0] + ofs;
    return {base[63:PAGE_BITS], low} + cnt;
  endfunction
endpackage

// File: rtl/dma_ofs_bank.sv
module dma_ofs_bank #(
  parameter int unsigned NUM_BUF = 8,
  parameter int unsigned OFS_W   = 12,
  localparam int unsigned BUF_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BUF_W-1:0] wr_buf,
  input  logic [OFS_W-1:0] wr_ofs,
  input  logic [BUF_W-1:0] cur_buf,
  output logic [OFS_W-1:0] sel_ofs
);
  logic [NUM_BUF-1:0][OFS_W-1:0] staged_q;
  logic [NUM_BUF-1:0][OFS_W-1:0] live_q;
  logic [BUF_W-1:0]              prev_buf_q;
  logic                          buf_switch;

  assign buf_switch = (cur_buf != prev_buf_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      staged_q   <= '0;
      live_q     <= '0;
      prev_buf_q <= '0;
    end else begin
      prev_buf_q <= cur_buf;
      if (wr_en) staged_q[wr_buf] <= wr_ofs;
      if (buf_switch) live_q <= staged_q;
    end
  end

  // During the switch cycle the staged copy is what becomes live.
  assign sel_ofs = buf_switch ? staged_q[cur_buf] : live_q[cur_buf];

  p_live_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_buf == prev_buf_q) |=> $stable(live_q));

  p_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_switch |=> (live_q == $past(staged_q)));
endmodule

// File: rtl/dma_ofs_stage.sv
module dma_ofs_stage #(
  parameter int unsigned PAY_W = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PAY_W-1:0] in_pay,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PAY_W-1:0] out_pay
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pay   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_pay <= in_pay;
    end
  end

  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (out_valid && out_pay == $past(in_pay)));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pay)));
endmodule

// File: rtl/dma_ofs_aligner.sv
module dma_ofs_aligner #(
  parameter int unsigned NUM_CH  = 12,
  parameter int unsigned NUM_BUF = 8,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned CNT_W   = 16,
  localparam int unsigned OFS_W  = dma_ofs_pkg::PAGE_BITS,
  localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned BUF_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
  localparam int unsigned PAY_W  = CH_W + ADDR_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [CH_W-1:0]         cfg_ch,
  input  logic [BUF_W-1:0]        cfg_buf,
  input  logic [OFS_W-1:0]        cfg_ofs,
  input  logic [NUM_CH*BUF_W-1:0] buf_idx,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [CH_W-1:0]         in_ch,
  input  logic [ADDR_W-1:0]       in_base,
  input  logic [CNT_W-1:0]        in_count,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [CH_W-1:0]         out_ch,
  output logic [ADDR_W-1:0]       out_addr
);
  import dma_ofs_pkg::*;

  logic [NUM_CH-1:0][OFS_W-1:0] ch_ofs;
  logic [OFS_W-1:0]             beat_ofs;
  logic [63:0]                  placed;
  logic [ADDR_W-1:0]            beat_addr;
  logic [PAY_W-1:0]             out_pay;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    dma_ofs_bank #(.NUM_BUF(NUM_BUF), .OFS_W(OFS_W)) bank_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we && (cfg_ch == CH_W'(c))),
      .wr_buf  (cfg_buf),
      .wr_ofs  (cfg_ofs),
      .cur_buf (buf_idx[c*BUF_W +: BUF_W]),
      .sel_ofs (ch_ofs[c])
    );
  end

  // Channel numbers beyond NUM_CH select offset zero.
  always_comb begin
    beat_ofs = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (in_ch == CH_W'(c)) beat_ofs = ch_ofs[c];
  end

  assign placed    = place_in_page(64'(in_base), beat_ofs, 64'(in_count));
  assign beat_addr = placed[ADDR_W-1:0];

  dma_ofs_stage #(.PAY_W(PAY_W)) stage_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_pay    ({in_ch, beat_addr}),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pay   (out_pay)
  );

  assign out_ch   = out_pay[PAY_W-1 -: CH_W];
  assign out_addr = out_pay[ADDR_W-1:0];

  p_page_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=>
      (((out_addr - ADDR_W'($past(in_count))) >> OFS_W) == ($past(in_base) >> OFS_W)));

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

// File: tb/dma_ofs_aligner_tb_top.sv
module dma_ofs_aligner_tb_top;
  localparam int NCH = 12;
  localparam int NB  = 8;
  localparam int BW  = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [3:0]        cfg_ch = '0;
  logic [2:0]        cfg_buf = '0;
  logic [11:0]       cfg_ofs = '0;
  logic [NCH*BW-1:0] buf_idx = '0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [3:0]        in_ch = '0;
  logic [31:0]       in_base = '0;
  logic [15:0]       in_count = '0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [3:0]        out_ch;
  logic [31:0]       out_addr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  int staged_m [NCH][NB];
  int live_m   [NCH][NB];
  int cur_m    [NCH];

  always #5 clk = ~clk;

  dma_ofs_aligner dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_buf(cfg_buf),
    .cfg_ofs(cfg_ofs), .buf_idx(buf_idx), .in_valid(in_valid), .in_ready(in_ready),
    .in_ch(in_ch), .in_base(in_base), .in_count(in_count), .out_valid(out_valid),
    .out_ready(out_ready), .out_ch(out_ch), .out_addr(out_addr)
  );

  function automatic logic [31:0] expect_addr(input logic [31:0] base, input int ofs,
                                               input logic [15:0] cnt);
    longint page, low;
    page = longint'(base) / 4096;
    low  = (longint'(base) % 4096 + ofs) % 4096;
    return 32'(page * 4096 + low + longint'(cnt));
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int ch, input int b, input int ofs);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 4'(ch); cfg_buf = 3'(b); cfg_ofs = 12'(ofs);
    staged_m[ch][b] = ofs;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_buf(input int ch, input int b);
    @(negedge clk);
    buf_idx[ch*BW +: BW] = 3'(b);
    cur_m[ch] = b;
    live_m[ch] = staged_m[ch];
    @(posedge clk);
  endtask

  // One beat; optionally switches the channel's buffer in the same cycle.
  task automatic beat(input int ch, input logic [31:0] base, input logic [15:0] cnt,
                      input string req, input int new_buf = -1);
    logic [31:0] exp;
    @(negedge clk);
    if (new_buf >= 0) begin
      buf_idx[ch*BW +: BW] = 3'(new_buf);
      cur_m[ch] = new_buf;
      live_m[ch] = staged_m[ch];
    end
    in_valid = 1'b1; in_ch = 4'(ch); in_base = base; in_count = cnt;
    exp = expect_addr(base, live_m[ch][cur_m[ch]], cnt);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, {req, " out_valid"}, longint'(out_valid), 1);
    check(out_addr == exp, {req, " out_addr"}, longint'(out_addr), longint'(exp));
    check(out_ch == 4'(ch), {req, " out_ch"}, longint'(out_ch), longint'(ch));
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", longint'(in_ready), 1);
    beat(0, 32'h0004_0ABC, 16'h0010, "R1 zero offset");
    beat(11, 32'h0000_1000, 16'h0000, "R1 zero offset last channel");
  endtask

  task automatic t_staged;
    cfg_write(2, 0, 12'h100);
    beat(2, 32'h0010_0000, 16'h0004, "R5 write not yet live");
    set_buf(2, 1);
    beat(2, 32'h0010_0000, 16'h0004, "R5 unwritten buffer zero");
    beat(3, 32'h0020_0000, 16'h0000, "R5 other channel unaffected");
    set_buf(2, 0);
    beat(2, 32'h0010_0000, 16'h0004, "R5 live after switch back");
  endtask

  task automatic t_per_buffer;
    cfg_write(5, 3, 12'h7FF);
    cfg_write(5, 4, 12'h010);
    set_buf(5, 3);
    beat(5, 32'h0030_0000, 16'h0020, "R4 buffer 3 offset");
    set_buf(5, 4);
    beat(5, 32'h0030_0000, 16'h0020, "R4 buffer 4 offset");
    beat(7, 32'h0030_0000, 16'h0020, "R3 channel 7 still zero");
    cfg_write(7, 0, 12'h055);
    set_buf(7, 6);
    set_buf(7, 0);
    beat(7, 32'h0030_0000, 16'h0001, "R3 channel 7 own offset");
    beat(5, 32'h0030_0000, 16'h0001, "R3 channel 5 kept buffer 4");
  endtask

  task automatic t_wrap;
    cfg_write(1, 1, 12'hFFF);
    set_buf(1, 1);
    beat(1, 32'h0001_2F00, 16'h0010, "R2 offset wraps in page");
    check(out_addr == 32'h0001_2F0F, "R2 literal wrap value", longint'(out_addr), 32'h0001_2F0F);
    beat(1, 32'hFFFF_F001, 16'h0002, "R2 top page wrap");
  endtask

  task automatic t_switch_beat;
    cfg_write(9, 2, 12'h123);
    beat(9, 32'h0050_0000, 16'h0008, "R6 beat in switch cycle", 2);
    check(out_addr == 32'h0050_012B, "R6 literal value", longint'(out_addr), 32'h0050_012B);
  endtask

  task automatic t_stall;
    logic [31:0] exp_a, exp_b;
    exp_a = expect_addr(32'h0060_0000, live_m[5][cur_m[5]], 16'h0003);
    exp_b = expect_addr(32'h0070_0000, live_m[9][cur_m[9]], 16'h0004);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_ch = 4'd5; in_base = 32'h0060_0000; in_count = 16'h0003;
    @(posedge clk);
    @(negedge clk);
    check(out_addr == exp_a, "R7 beat A after one edge", longint'(out_addr), longint'(exp_a));
    check(in_ready == 1'b0, "R8 in_ready low in stall", longint'(in_ready), 0);
    in_ch = 4'd9; in_base = 32'h0070_0000; in_count = 16'h0004;
    @(posedge clk);
    @(negedge clk);
    check(out_addr == exp_a, "R8 addr held in stall", longint'(out_addr), longint'(exp_a));
    check(out_ch == 4'd5, "R8 channel held in stall", longint'(out_ch), 5);
    check(out_valid == 1'b1, "R8 valid held in stall", longint'(out_valid), 1);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_addr == exp_b, "R7 queued beat B", longint'(out_addr), longint'(exp_b));
    check(out_ch == 4'd9, "R7 queued channel", longint'(out_ch), 9);
    @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R7 valid drops", longint'(out_valid), 0);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      cur_m[c] = 0;
      for (int b = 0; b < NB; b++) begin
        staged_m[c][b] = 0;
        live_m[c][b]   = 0;
      end
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_staged();
    t_per_buffer();
    t_wrap();
    t_switch_beat();
    t_stall();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule